// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects event pulses from a network controller into a 32-bit event register and gates them with a 32-bit mask register. It drives thirteen separate interrupt lines. Each line follows one event bit ANDed with the matching mask bit. Engines inside the controller raise events with single-cycle pulses. Host software reads both registers through a small register port, acknowledges events by writing ones to the event register, and rewrites the whole mask in one access.

Only thirteen high-order event positions exist. All other event bits always read as zero. The interrupt lines are registered, so they follow the gated event state one cycle later. An active-low controller reset clears the registers and the lines.

Top module: `irq_event_ctrl`

## Requirements
- R1: While `rst_n` is low, the event register, the mask register and all thirteen `irq_o` lines are zero.
- R2: A pulse on `evt_pulse` at a defined position (bits 31 down to 19) sets that event bit. The new value is visible on `reg_rdata` from the cycle after the pulse. Set bits stay set until the host clears them.
- R3: Event bits 18 down to 0 always read as zero, and pulses on those positions have no effect.
- R4: A host write at offset 0x004 clears every event bit that is 1 in `reg_wdata`. All other event bits keep their value. A write with all zeros changes nothing.
- R5: A host write at offset 0x008 replaces all 32 mask bits with `reg_wdata`. The mask reads back in full at offset 0x008.
- R6: If a set pulse and a host clear hit the same event bit in the same cycle, the bit ends up set.
- R7: The `irq_o` lines 0 to 12 follow event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29 and 30, in that order. Each line is high only when both its event bit and its mask bit are 1.
- R8: `irq_o` is registered. It takes the gated value of the event and mask state one clock after that state changes.
- R9: Reads at any offset other than 0x004 and 0x008 return zero. Writes at other offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low controller reset, asynchronous assert |
| evt_pulse | input | 32 | Single-cycle event set pulses, in event-register bit positions |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 10 | Host byte offset for read and write |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for the selected offset, combinational |
| irq_o | output | 13 | Masked, registered interrupt lines |

## Verification
The assertions assume that the host port holds stable values across each rising edge. They also assume `evt_pulse` may carry any pattern, including undefined positions and bits being cleared in the same cycle. They check register state one cycle after each write or pulse, so they rely on the write strobe standing for a single clock edge per access. The stimulus drives every input on the falling edge and keeps each access to one cycle. It deliberately sets undefined pulse bits and overlapping set and clear patterns so that those assumptions are exercised.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 10,
  parameter int NUM_IRQ  = 13,
  parameter logic [ADDR_W-1:0] EVT_OFS = 10'h004,
  parameter logic [ADDR_W-1:0] MSK_OFS = 10'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_IRQ-1:0] irq_o
);

  localparam int LINE_BIT [NUM_IRQ] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  logic [DATA_W-1:0] impl_bits;
  always_comb begin
    impl_bits = '0;
    for (int i = 0; i < NUM_IRQ; i++) impl_bits[LINE_BIT[i]] = 1'b1;
  end

  logic [DATA_W-1:0] event_q, mask_q, gated, clr_vec, set_vec;
  logic evt_wr, msk_wr;

  assign evt_wr  = reg_we && (reg_addr == EVT_OFS);
  assign msk_wr  = reg_we && (reg_addr == MSK_OFS);
  assign clr_vec = evt_wr ? reg_wdata : '0;
  assign set_vec = evt_pulse & impl_bits;
  assign gated   = event_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= '0;
      mask_q  <= '0;
    end else begin
      event_q <= (event_q & ~clr_vec) | set_vec;
      if (msk_wr) mask_q <= reg_wdata;
    end
  end

  logic [NUM_IRQ-1:0] line_d;
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    assign line_d[n] = gated[LINE_BIT[n]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= line_d;
  end

  assign reg_rdata = (reg_addr == EVT_OFS) ? event_q :
                     (reg_addr == MSK_OFS) ? mask_q  : '0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0) || !rst_n);

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & $past(evt_pulse & impl_bits)) == $past(evt_pulse & impl_bits)));

  assert_undef_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == EVT_OFS) |-> ((reg_rdata & ~impl_bits) == '0));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && evt_pulse == '0) |=> (event_q == ($past(event_q) & ~$past(reg_wdata))));

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr |=> (mask_q == $past(reg_wdata)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && evt_pulse[27] && reg_wdata[27]) |=> event_q[27]);

  assert_line0_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[0] == $past(event_q[27] & mask_q[27])));

  assert_line12_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[12] == $past(event_q[30] & mask_q[30])));

  assert_irq_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(event_q & mask_q) |=> $stable(irq_o));

  assert_other_ofs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !evt_wr && !msk_wr) |=> (mask_q == $past(mask_q)));

endmodule

// File: tb/irq_event_ctrl_test.sv
module irq_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = 10'h004;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] irq_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  localparam int MAP [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
  localparam int NV = 10;
  localparam logic [31:0] V_PULSE [NV] = '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h00080000, 32'h00000001,
                                          32'h0, 32'h80000000, 32'h40000000, 32'h0, 32'h0};
  localparam logic        V_WE    [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [9:0]  V_ADDR  [NV] = '{10'h004, 10'h008, 10'h004, 10'h004, 10'h004,
                                          10'h008, 10'h004, 10'h008, 10'h004, 10'h008};
  localparam logic [31:0] V_WDATA [NV] = '{32'h0, 32'hFFFFFFFF, 32'h08000000, 32'hFFFFFFFF, 32'h0,
                                          32'h80000000, 32'h0, 32'h40000000, 32'h0, 32'h0};
  localparam logic [31:0] V_EVT   [NV] = '{32'hFFF80000, 32'hFFF80000, 32'hF7F80000, 32'h00080000,
                                          32'h00080000, 32'h00080000, 32'h80080000, 32'hC0080000,
                                          32'hC0080000, 32'hC0080000};
  localparam logic [31:0] V_MSK   [NV] = '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'h40000000,
                                          32'h40000000, 32'h0};

  function automatic logic [12:0] exp_irq(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int n = 0; n < 13; n++) r[n] = e[MAP[n]] & m[MAP[n]];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input logic [31:0] p, input logic we, input logic [9:0] a, input logic [31:0] w);
    evt_pulse = p; reg_we = we; reg_addr = a; reg_wdata = w;
    @(negedge clk);
    evt_pulse = '0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [12:0] prev_irq;
    repeat (2) @(negedge clk);
    rd(10'h004, d); chk("R1 event", d, 32'h0);
    rd(10'h008, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {19'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    prev_irq = '0;
    for (int v = 0; v < NV; v++) begin
      step(V_PULSE[v], V_WE[v], V_ADDR[v], V_WDATA[v]);
      rd(10'h004, d); chk("R2 R3 R4 R6 event", d, V_EVT[v]);
      rd(10'h008, d); chk("R5 mask", d, V_MSK[v]);
      chk("R8 irq holds one cycle", {19'h0, irq_o}, {19'h0, prev_irq});
      @(negedge clk);
      chk("R7 irq map", {19'h0, irq_o}, {19'h0, exp_irq(V_EVT[v], V_MSK[v])});
      prev_irq = exp_irq(V_EVT[v], V_MSK[v]);
    end

    step(32'h0, 1'b1, 10'h004, 32'hFFFFFFFF);
    for (int n = 0; n < 13; n++) begin
      step(32'h0, 1'b1, 10'h008, 32'h1 << MAP[n]);
      step(32'h1 << MAP[n], 1'b0, 10'h004, 32'h0);
      @(negedge clk);
      chk("R7 single line", {19'h0, irq_o}, 32'h1 << n);
      step(32'h0, 1'b1, 10'h004, 32'h1 << MAP[n]);
      @(negedge clk);
      chk("R4 cleared line", {19'h0, irq_o}, 32'h0);
    end

    step(32'h0007FFFF, 1'b0, 10'h004, 32'h0);
    rd(10'h004, d); chk("R3 undefined pulses", d, 32'h0);

    step(32'h00100000, 1'b1, 10'h004, 32'h0);
    step(32'h0, 1'b1, 10'h008, 32'h12345678);
    step(32'h0, 1'b1, 10'h00C, 32'hFFFFFFFF);
    step(32'h0, 1'b1, 10'h000, 32'hFFFFFFFF);
    rd(10'h004, d); chk("R9 event kept", d, 32'h00100000);
    rd(10'h008, d); chk("R9 mask kept", d, 32'h12345678);
    rd(10'h00C, d); chk("R9 read zero", d, 32'h0);

    step(32'h0, 1'b1, 10'h008, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R7 retry line", {19'h0, irq_o}, 32'h0008);
    rst_n = 1'b0;
    #1;
    rd(10'h004, d); chk("R1 event mid-run", d, 32'h0);
    rd(10'h008, d); chk("R1 mask mid-run", d, 32'h0);
    chk("R1 irq mid-run", {19'h0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule